// File: doc/BRIEF.md
# Debug Request and Interrupt Gating Control

This block is a three-bit control register inside an on-chip debug unit. A scan-chain front end reaches it with single-cycle accesses: a strobe, a direction flag and three data bits. The stored bits shape three signals toward the processor core. The first is the core's interrupt enable. Interrupts are blocked when software-visible disable is set, and also while the core is acknowledged as being in debug. The second is a debug request, which merges an external request with a forced request bit. The third is a debug acknowledge that can be forced on.

The forced request bit does not reach the core straight away. It passes through a hold stage that only takes a new value on clock edges where the TAP controller reports Run-Test/Idle. A debugger can therefore arm the request in several processors while they keep running, and then release all of them together by entering Run-Test/Idle. The hold stage is a clocked register loaded under an enable. This keeps the design free of level-sensitive latches.

Top module: `dbg_ctl_gate`

## Requirements
- R1: While `rst_n` is low, and after it rises with no access made, the stored bits and the request hold stage are zero. `irq_en` is then 1, `req_out` follows `ext_req`, `ack_out` follows `core_ack`, and a read returns 3'b000.
- R2: On a clock edge with `acc_stb`=1 and `acc_wr`=1, `wr_data` is stored. Bit 2 is interrupt disable, bit 1 is request force and bit 0 is acknowledge force.
- R3: While `acc_stb`=1 and `acc_wr`=0, `rd_data` shows the stored bits in the same bit positions. It shows the stored register, not the combined external signals. At all other times `rd_data` is 3'b000.
- R4: A read access leaves the stored bits unchanged.
- R5: `irq_en` is 1 only when bit 2 is 0 and `ack_out` is 0. Otherwise it is 0.
- R6: `ack_out` is the OR of `core_ack` and bit 0, with no clock delay.
- R7: `req_out` is the OR of `ext_req` and the request hold stage, with no clock delay from `ext_req`.
- R8: The hold stage copies stored bit 1 on each clock edge where `tap_idle`=1. It keeps its value on every edge where `tap_idle`=0. A bit 1 write takes effect on `req_out` one edge after the write edge, provided `tap_idle` is 1 at that later edge.
- R9: Clearing bit 1 outside Run-Test/Idle leaves `req_out` asserted until `tap_idle` is 1 at a clock edge.
- R10: A clock edge with `acc_stb`=0 stores nothing, whatever `acc_wr` and `wr_data` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_stb | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| wr_data | input | 3 | Write data {irq disable, request force, ack force} |
| rd_data | output | 3 | Read data, stored bits during a read access |
| tap_idle | input | 1 | High while the TAP controller is in Run-Test/Idle |
| ext_req | input | 1 | External debug request |
| core_ack | input | 1 | Debug acknowledge from the core |
| irq_en | output | 1 | Interrupt enable to the core |
| req_out | output | 1 | Debug request to the core, also brought out |
| ack_out | output | 1 | Debug acknowledge, possibly forced |

## Verification
The bench walks all eight combinations of disable bit, acknowledge-force bit and core acknowledge. A design that gated interrupts on the raw core acknowledge instead of the forced one would leave `irq_en` high when only bit 0 is set. A second group of checks arms the request outside Run-Test/Idle, then clears it outside Run-Test/Idle. A design with a transparent path, or a hold stage that opens in the wrong state, would change `req_out` early or drop it early. A final group checks that the hold stage lags a write by exactly one edge, that a strobe-less write is ignored, and that a read leaves the register as it was.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
    localparam int CTRL_W = 3;

    typedef struct packed {
        logic irq_dis;    // bit 2
        logic req_force;  // bit 1
        logic ack_force;  // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{irq_dis: 1'b0, req_force: 1'b0, ack_force: 1'b0};
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
    import dbg_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              acc_wr,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (acc_stb && acc_wr) begin
            ctrl_d = ctrl_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign rd_data = (acc_stb && !acc_wr) ? CTRL_W'(ctrl_q) : '0;
endmodule

// File: rtl/dbg_req_hold.sv
module dbg_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic open_en,
    input  logic req_in,
    output logic hold_q
);
    logic hold_d;

    always_comb begin
        hold_d = hold_q;
        if (open_en) begin
            hold_d = req_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/dbg_irq_gate.sv
module dbg_irq_gate (
    input  logic irq_dis,
    input  logic ack_force,
    input  logic req_held,
    input  logic ext_req,
    input  logic core_ack,
    output logic irq_en,
    output logic req_out,
    output logic ack_out
);
    logic ack_any;

    always_comb begin
        ack_any = core_ack | ack_force;
        ack_out = ack_any;
        req_out = ext_req | req_held;
        irq_en  = ~(irq_dis | ack_any);
    end
endmodule

// File: rtl/dbg_ctl_gate.sv
module dbg_ctl_gate
    import dbg_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic              acc_wr,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              tap_idle,
    input  logic              ext_req,
    input  logic              core_ack,
    output logic              irq_en,
    output logic              req_out,
    output logic              ack_out
);
    ctrl_t ctrl_q;
    logic  req_held_q;

    dbg_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_stb (acc_stb),
        .acc_wr  (acc_wr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q)
    );

    dbg_req_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_en (tap_idle),
        .req_in  (ctrl_q.req_force),
        .hold_q  (req_held_q)
    );

    dbg_irq_gate u_gate (
        .irq_dis   (ctrl_q.irq_dis),
        .ack_force (ctrl_q.ack_force),
        .req_held  (req_held_q),
        .ext_req   (ext_req),
        .core_ack  (core_ack),
        .irq_en    (irq_en),
        .req_out   (req_out),
        .ack_out   (ack_out)
    );
endmodule

// File: rtl/dbg_ctl_gate_chk.sv
module dbg_ctl_gate_chk
    import dbg_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_stb,
    input logic              acc_wr,
    input logic [CTRL_W-1:0] wr_data,
    input logic              tap_idle,
    input logic              ext_req,
    input logic              core_ack,
    input logic              irq_en,
    input logic              req_out,
    input logic              ack_out,
    input ctrl_t             ctrl_q,
    input logic              req_held_q
);
    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_wr) |=> (ctrl_q == ctrl_t'($past(wr_data))));

    // R4
    read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && !acc_wr) |=> $stable(ctrl_q));

    // R10
    idle_bus_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> $stable(ctrl_q));

    // R5
    irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.irq_dis || ack_out) |-> !irq_en);

    // R6
    ack_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack || ctrl_q.ack_force) |-> ack_out);

    // R7
    ext_req_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> req_out);

    // R8
    hold_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_idle |=> $stable(req_held_q));

    // R8
    hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_idle |=> (req_held_q == $past(ctrl_q.req_force)));
endmodule

bind dbg_ctl_gate dbg_ctl_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_stb    (acc_stb),
    .acc_wr     (acc_wr),
    .wr_data    (wr_data),
    .tap_idle   (tap_idle),
    .ext_req    (ext_req),
    .core_ack   (core_ack),
    .irq_en     (irq_en),
    .req_out    (req_out),
    .ack_out    (ack_out),
    .ctrl_q     (ctrl_q),
    .req_held_q (req_held_q)
);

// File: tb/dbg_ctl_gate_test.sv
module dbg_ctl_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_stb = 1'b0;
    logic       acc_wr = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic [2:0] rd_data;
    logic       tap_idle = 1'b0;
    logic       ext_req = 1'b0;
    logic       core_ack = 1'b0;
    logic       irq_en;
    logic       req_out;
    logic       ack_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbg_ctl_gate uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_stb  (acc_stb),
        .acc_wr   (acc_wr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .tap_idle (tap_idle),
        .ext_req  (ext_req),
        .core_ack (core_ack),
        .irq_en   (irq_en),
        .req_out  (req_out),
        .ack_out  (ack_out)
    );

    // vector: {irq_dis, ack_force, core_ack, exp_irq_en, exp_ack_out}
    localparam logic [4:0] VEC [8] = '{
        5'b000_10, 5'b001_01, 5'b010_01, 5'b011_01,
        5'b100_00, 5'b101_01, 5'b110_01, 5'b111_01
    };

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] d);
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = 1'b1; wr_data = d;
        @(negedge clk);
        acc_stb = 1'b0; acc_wr = 1'b0; wr_data = 3'b000;
    endtask

    task automatic rd_reg(output logic [2:0] d);
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = 1'b0;
        #2 d = rd_data;
        @(negedge clk);
        acc_stb = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] r;
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 irq_en in reset", {2'b0, irq_en}, 3'b001);
        chk("R1 req_out in reset", {2'b0, req_out}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack_out after reset", {2'b0, ack_out}, 3'b000);
        rd_reg(r);
        chk("R1 read after reset", r, 3'b000);
        chk("R3 rd_data idle bus", rd_data, 3'b000);

        // R5 R6: full truth table
        for (int i = 0; i < 8; i++) begin
            wr_reg({VEC[i][4], 1'b0, VEC[i][3]});
            core_ack = VEC[i][2];
            #2;
            chk($sformatf("R5 irq_en vec %0d", i), {2'b0, irq_en}, {2'b0, VEC[i][1]});
            chk($sformatf("R6 ack_out vec %0d", i), {2'b0, ack_out}, {2'b0, VEC[i][0]});
        end
        core_ack = 1'b0;

        // R2 R3: write then read back
        wr_reg(3'b101);
        rd_reg(r);
        chk("R2 R3 readback 101", r, 3'b101);
        // R3: read shows stored bits, not external ones
        core_ack = 1'b1; ext_req = 1'b1;
        wr_reg(3'b000);
        rd_reg(r);
        chk("R3 read ignores external", r, 3'b000);
        chk("R7 ext_req passes", {2'b0, req_out}, 3'b001);
        core_ack = 1'b0; ext_req = 1'b0;

        // R4: repeated reads keep value
        wr_reg(3'b110);
        rd_reg(r);
        rd_reg(r);
        chk("R4 read has no side effect", r, 3'b110);

        // R10: write with strobe low ignored
        @(negedge clk);
        acc_stb = 1'b0; acc_wr = 1'b1; wr_data = 3'b001;
        @(negedge clk);
        acc_wr = 1'b0; wr_data = 3'b000;
        rd_reg(r);
        chk("R10 strobe low ignored", r, 3'b110);

        // R8: armed outside idle, held until idle
        tap_idle = 1'b0;
        wr_reg(3'b010);
        repeat (3) @(negedge clk);
        chk("R8 request held outside idle", {2'b0, req_out}, 3'b000);
        tap_idle = 1'b1;
        @(negedge clk);
        chk("R8 request released in idle", {2'b0, req_out}, 3'b001);

        // R9: clear outside idle keeps request
        tap_idle = 1'b0;
        wr_reg(3'b000);
        repeat (2) @(negedge clk);
        chk("R9 request kept after clear", {2'b0, req_out}, 3'b001);
        tap_idle = 1'b1;
        @(negedge clk);
        chk("R9 request drops in idle", {2'b0, req_out}, 3'b000);

        // R8: in idle, one-edge lag after the write edge
        @(negedge clk);
        acc_stb = 1'b1; acc_wr = 1'b1; wr_data = 3'b010;
        @(negedge clk);
        acc_stb = 1'b0; acc_wr = 1'b0; wr_data = 3'b000;
        chk("R8 no change at write edge", {2'b0, req_out}, 3'b000);
        @(negedge clk);
        chk("R8 change one edge later", {2'b0, req_out}, 3'b001);
        tap_idle = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule